// File: doc/BRIEF.md
# SHA-256 Double-Round Compression Unit

This block advances the SHA-256 compression function by two rounds per operation. The eight 32-bit working variables arrive split across two 128-bit operands. One operand carries the four variables that change most directly: A, B, E and F. The other carries the four that are only shifted along: C, D, G and H. A third 64-bit operand carries, for each of the two rounds, the message-schedule word already added to its round constant.

The result is the new A, B, E and F packing after both rounds. The caller moves its previous A/B/E/F operand into the C/D/G/H slot for the next operation. A full 512-bit block therefore needs thirty-two operations. Message expansion, the constant table and the final addition into the chaining value belong to the caller.

Operands are accepted with a valid/ready handshake, and the result is offered the same way. The parameter `RNDS_PER_STEP` selects between two variants. With 2, both rounds are chained in one combinational step. With 1, one round is computed per clock over two cycles. The result is the same either way.

Top module: `sha2_dround`

## Requirements
- R1: After reset `inReady` is 1 and `outValid` is 0.
- R2: Lane order of the packed operands. In `abefIn` and `abefOut`, A is bits 127:96, B is 95:64, E is 63:32 and F is 31:0. In `cdghIn`, C is bits 127:96, D is 95:64, G is 63:32 and H is 31:0.
- R3: Each round computes T1 = H + S1(E) + Ch(E,F,G) + WK and T2 = S0(A) + Maj(A,B,C). The variables then shift: H=G, G=F, F=E, E=D+T1, D=C, C=B, B=A, A=T1+T2. Here S0 = rotr2^rotr13^rotr22, S1 = rotr6^rotr11^rotr25, Ch(x,y,z) = (x&y)^(~x&z) and Maj(x,y,z) = (x&y)^(x&z)^(y&z).
- R4: `wkIn[31:0]` is used by the first round and `wkIn[63:32]` by the second; swapping the halves changes the result accordingly.
- R5: Every addition wraps modulo 2^32.
- R6: An operation is accepted only on a cycle where both `inValid` and `inReady` are 1. `inReady` is 0 from acceptance until the result has been taken, and inputs presented during that time have no effect.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `abefOut` holds its value.
- R8: `outValid` rises `2/RNDS_PER_STEP` clock edges after the accepting edge.
- R9: Thirty-two chained operations over the padded block for the message "abc", plus the initial hash values, give digest ba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad.
- R10: `outValid` is 1 for exactly one handshake per accepted operation and falls on the cycle after `outValid` and `outReady` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands are present |
| inReady | output | 1 | Unit can take operands |
| abefIn | input | 128 | Packed A, B, E, F |
| cdghIn | input | 128 | Packed C, D, G, H |
| wkIn | input | 64 | W+K for the second round (upper half) and first round (lower half) |
| outValid | output | 1 | Result is present |
| outReady | input | 1 | Consumer takes the result |
| abefOut | output | 128 | New A, B, E, F after two rounds |

## Verification
The bench builds the block twice and drives both copies with the same stimulus. One copy uses `RNDS_PER_STEP` = 2 and chains both rounds in one step; the other uses 1 and iterates over two cycles. Running both copies exercises the shifting of the W+K operand between cycles as well as the two-round combinational path. Both latencies are checked, and both copies must agree on every one of the thirty-two operations of the known-answer block.

// File: rtl/dround_pkg.sv
package dround_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int PACK_W = LANES * WORD_W;
  localparam int PAIR_W = 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } work_t;

  typedef struct packed {
    logic load;
    logic step;
  } strobe_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t chooseFn(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majorFn(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic work_t oneRound(input work_t s, input word_t wk);
    word_t t1, t2;
    work_t n;
    t1 = s.h + bigSig1(s.e) + chooseFn(s.e, s.f, s.g) + wk;
    t2 = bigSig0(s.a) + majorFn(s.a, s.b, s.c);
    n.h = s.g;
    n.g = s.f;
    n.f = s.e;
    n.e = s.d + t1;
    n.d = s.c;
    n.c = s.b;
    n.b = s.a;
    n.a = t1 + t2;
    return n;
  endfunction
endpackage

// File: rtl/dround_path.sv
module dround_path import dround_pkg::*; #(
  parameter int RNDS_PER_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [PACK_W-1:0] abefIn,
  input  logic [PACK_W-1:0] cdghIn,
  input  logic [PAIR_W-1:0] wkIn,
  output logic [PACK_W-1:0] abefOut
);
  work_t             work;
  work_t             workNext;
  work_t             loaded;
  logic [PAIR_W-1:0] wkReg;

  always_comb begin
    loaded.a = abefIn[4*WORD_W-1:3*WORD_W];
    loaded.b = abefIn[3*WORD_W-1:2*WORD_W];
    loaded.e = abefIn[2*WORD_W-1:WORD_W];
    loaded.f = abefIn[WORD_W-1:0];
    loaded.c = cdghIn[4*WORD_W-1:3*WORD_W];
    loaded.d = cdghIn[3*WORD_W-1:2*WORD_W];
    loaded.g = cdghIn[2*WORD_W-1:WORD_W];
    loaded.h = cdghIn[WORD_W-1:0];
  end

  generate
    if (RNDS_PER_STEP == 2) begin : g_chained
      always_comb workNext = oneRound(oneRound(work, wkReg[WORD_W-1:0]),
                                      wkReg[PAIR_W-1:WORD_W]);
    end else begin : g_iterated
      always_comb workNext = oneRound(work, wkReg[WORD_W-1:0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work  <= '0;
      wkReg <= '0;
    end else if (strobes.load) begin
      work  <= loaded;
      wkReg <= wkIn;
    end else if (strobes.step) begin
      work  <= workNext;
      wkReg <= {{WORD_W{1'b0}}, wkReg[PAIR_W-1:WORD_W]};
    end
  end

  assign abefOut = {work.a, work.b, work.e, work.f};
endmodule

// File: rtl/dround_ctrl.sv
module dround_ctrl import dround_pkg::*; #(
  parameter int STEPS = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  output logic    outValid,
  input  logic    outReady,
  output strobe_t strobes
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} ctrl_state_e;

  ctrl_state_e      state;
  logic [CW-1:0]    stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (inValid) begin
          state   <= ST_BUSY;
          stepCnt <= '0;
        end
        ST_BUSY: if (stepCnt == CW'(STEPS - 1)) state <= ST_DONE;
                 else stepCnt <= stepCnt + 1'b1;
        ST_DONE: if (outReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inReady      = (state == ST_IDLE);
  assign outValid     = (state == ST_DONE);
  assign strobes.load = inReady && inValid;
  assign strobes.step = (state == ST_BUSY);
endmodule

// File: rtl/sha2_dround.sv
module sha2_dround import dround_pkg::*; #(
  parameter int RNDS_PER_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PACK_W-1:0] abefIn,
  input  logic [PACK_W-1:0] cdghIn,
  input  logic [PAIR_W-1:0] wkIn,
  output logic              outValid,
  input  logic              outReady,
  output logic [PACK_W-1:0] abefOut
);
  localparam int STEPS = 2 / RNDS_PER_STEP;

  strobe_t strobes;

  dround_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobes(strobes)
  );

  dround_path #(.RNDS_PER_STEP(RNDS_PER_STEP)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .abefIn(abefIn),
    .cdghIn(cdghIn), .wkIn(wkIn), .abefOut(abefOut)
  );
endmodule

// File: rtl/dround_checker.sv
module dround_checker #(
  parameter int RNDS_PER_STEP = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         inReady,
  input logic         outValid,
  input logic         outReady,
  input logic [127:0] abefOut
);
  localparam int LAT = 2 / RNDS_PER_STEP;

  logic [2:0] sinceAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceAcc <= '0;
    else if (inValid && inReady) sinceAcc <= 3'd1;
    else if (sinceAcc != 3'd0 && sinceAcc != 3'd7) sinceAcc <= sinceAcc + 3'd1;
  end

  // R6: never ready while a result is pending
  a_r6_ready_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  // R6: busy right after acceptance
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R7: result held under back-pressure
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(abefOut)));

  // R8: result appears after the configured number of edges
  a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (sinceAcc == 3'(LAT + 1)));

  // R10: one handshake per operation
  a_r10_once: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> !outValid);
endmodule

bind sha2_dround dround_checker #(.RNDS_PER_STEP(RNDS_PER_STEP)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .abefOut(abefOut)
);

// File: tb/test_sha2_dround.sv
module test_sha2_dround;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] abefIn = '0;
  logic [127:0] cdghIn = '0;
  logic [63:0]  wkIn = '0;
  logic         outReady = 1'b1;
  logic         inReadyF, inReadyS, outValidF, outValidS;
  logic [127:0] abefOutF, abefOutS;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sha2_dround #(.RNDS_PER_STEP(2)) i_sha2_dround (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReadyF),
    .abefIn(abefIn), .cdghIn(cdghIn), .wkIn(wkIn), .outValid(outValidF),
    .outReady(outReady), .abefOut(abefOutF)
  );

  sha2_dround #(.RNDS_PER_STEP(1)) i_sha2_dround_iter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReadyS),
    .abefIn(abefIn), .cdghIn(cdghIn), .wkIn(wkIn), .outValid(outValidS),
    .outReady(outReady), .abefOut(abefOutS)
  );

  localparam logic [31:0] K_TAB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };
  localparam logic [255:0] H_INIT =
    256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [255:0] ABC_DIGEST =
    256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // Reference: 8 words in order a,b,c,d,e,f,g,h, one round
  function automatic logic [255:0] refRound(input logic [255:0] s, input logic [31:0] wk);
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    {a, b, c, d, e, f, g, h} = s;
    t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + wk;
    t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
    return {t1 + t2, a, b, c, d + t1, e, f, g};
  endfunction

  function automatic logic [127:0] refDouble(input logic [127:0] abef,
                                             input logic [127:0] cdgh,
                                             input logic [63:0] wk);
    logic [255:0] s;
    s = {abef[127:64], cdgh[127:64], abef[63:0], cdgh[63:0]};
    s = refRound(s, wk[31:0]);
    s = refRound(s, wk[63:32]);
    return {s[255:192], s[127:64]};
  endfunction

  task automatic expectEq(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [127:0] resF, resS;
  int           latF, latS;
  logic         lowAfterF;

  // Drive one operation into both copies with outReady held high
  task automatic runOp(input logic [127:0] abef, input logic [127:0] cdgh, input logic [63:0] wk);
    bit gotF, gotS;
    @(negedge clk);
    abefIn = abef; cdghIn = cdgh; wkIn = wk; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    gotF = 0; gotS = 0; lowAfterF = 1'b1;
    for (int n = 1; n <= 8 && !(gotF && gotS); n++) begin
      if (gotF && outValidF) lowAfterF = 1'b0;
      if (!gotF && outValidF) begin resF = abefOutF; latF = n; gotF = 1; end
      if (!gotS && outValidS) begin resS = abefOutS; latS = n; gotS = 1; end
      if (!(gotF && gotS)) @(negedge clk);
    end
  endtask

  task automatic testReset();
    expectEq("R1 inReady fast", {255'b0, inReadyF}, 256'd1);
    expectEq("R1 inReady iter", {255'b0, inReadyS}, 256'd1);
    expectEq("R1 outValid fast", {255'b0, outValidF}, 256'd0);
    expectEq("R1 outValid iter", {255'b0, outValidS}, 256'd0);
  endtask

  task automatic testOp(input string tag, input logic [127:0] abef,
                        input logic [127:0] cdgh, input logic [63:0] wk);
    logic [127:0] exp;
    exp = refDouble(abef, cdgh, wk);
    runOp(abef, cdgh, wk);
    expectEq({tag, " fast"}, {128'b0, resF}, {128'b0, exp});
    expectEq({tag, " iter"}, {128'b0, resS}, {128'b0, exp});
  endtask

  task automatic testLatency();
    runOp(H_INIT[255:128], H_INIT[127:0], 64'h0123_4567_89ab_cdef);
    expectEq("R8 latency fast", 256'(latF), 256'd2);
    expectEq("R8 latency iter", 256'(latS), 256'd3);
    expectEq("R10 fast valid drops after handshake", {255'b0, lowAfterF}, 256'd1);
  endtask

  task automatic testWkOrder();
    logic [127:0] abef, cdgh, expSwap;
    abef = 128'h11111111_22222222_33333333_44444444;
    cdgh = 128'h55555555_66666666_77777777_88888888;
    expSwap = refDouble(abef, cdgh, 64'h00000001_deadbeef);
    runOp(abef, cdgh, 64'h00000001_deadbeef);
    expectEq("R4 low half first", {128'b0, resF}, {128'b0, expSwap});
    runOp(abef, cdgh, 64'hdeadbeef_00000001);
    expectEq("R4 swapped halves differ", {255'b0, resF == expSwap}, 256'd0);
    expectEq("R4 swapped halves value", {128'b0, resF},
             {128'b0, refDouble(abef, cdgh, 64'hdeadbeef_00000001)});
  endtask

  task automatic testStall();
    logic [127:0] abef, cdgh, exp;
    abef = 128'hcafef00d_0badc0de_feedface_13579bdf;
    cdgh = 128'h2468ace0_89abcdef_01234567_fedcba98;
    exp = refDouble(abef, cdgh, 64'h55aa55aa_a5a5a5a5);
    @(negedge clk);
    outReady = 1'b0;
    abefIn = abef; cdghIn = cdgh; wkIn = 64'h55aa55aa_a5a5a5a5; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    expectEq("R7 held valid", {254'b0, outValidF, outValidS}, 256'd3);
    expectEq("R7 held value fast", {128'b0, abefOutF}, {128'b0, exp});
    expectEq("R6 not ready while pending", {254'b0, inReadyF, inReadyS}, 256'd0);
    abefIn = ~abef; cdghIn = ~cdgh; wkIn = 64'h1; inValid = 1'b1;
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    expectEq("R6 ignored inputs fast", {128'b0, abefOutF}, {128'b0, exp});
    expectEq("R6 ignored inputs iter", {128'b0, abefOutS}, {128'b0, exp});
    outReady = 1'b1;
    @(negedge clk);
    expectEq("R10 valid falls after take", {254'b0, outValidF, outValidS}, 256'd0);
    repeat (3) @(negedge clk);
    expectEq("R10 valid stays low", {254'b0, outValidF, outValidS}, 256'd0);
    expectEq("R6 ready again", {254'b0, inReadyF, inReadyS}, 256'd3);
  endtask

  task automatic testBlock();
    logic [31:0]  w [64];
    logic [31:0]  a, b, c, d, e, f, g, h, s0, s1;
    logic [255:0] digest;
    int           mism = 0;
    for (int t = 0; t < 16; t++) w[t] = 32'h0;
    w[0]  = 32'h61626380;
    w[15] = 32'h00000018;
    for (int t = 16; t < 64; t++) begin
      s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
      s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
      w[t] = w[t-16] + s0 + w[t-7] + s1;
    end
    {a, b, c, d, e, f, g, h} = H_INIT;
    for (int i = 0; i < 32; i++) begin
      runOp({a, b, e, f}, {c, d, g, h},
            {w[2*i+1] + K_TAB[2*i+1], w[2*i] + K_TAB[2*i]});
      if (resS !== resF) mism++;
      {c, d, g, h} = {a, b, e, f};
      {a, b, e, f} = resF;
    end
    digest = {a + H_INIT[255:224], b + H_INIT[223:192], c + H_INIT[191:160],
              d + H_INIT[159:128], e + H_INIT[127:96],  f + H_INIT[95:64],
              g + H_INIT[63:32],   h + H_INIT[31:0]};
    expectEq("R9 abc digest", digest, ABC_DIGEST);
    expectEq("R9 iterated copy agrees on every call", 256'(mism), 256'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL R8 watchdog: cycles %0d expected below %0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // R2 / R3: lane order and round arithmetic on the initial hash state
    testOp("R2 R3 initial state", H_INIT[255:128], H_INIT[127:0], 64'h71374491_428a2f98);
    testOp("R3 mixed pattern", 128'h0f0f0f0f_f0f0f0f0_12345678_9abcdef0,
           128'h80000000_00000001_aaaaaaaa_55555555, 64'h00000000_00000000);
    // R5: all-ones operands force carries out of every adder
    testOp("R5 wraparound", {4{32'hffffffff}}, {4{32'hffffffff}}, {2{32'hffffffff}});
    testLatency();
    testWkOrder();
    testStall();
    testBlock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule